// File: doc/BRIEF.md
# Voice Parameter Register File

This block holds the per-voice parameter words of a wavetable synthesis engine. It is organised as a bank of voices, each with sixteen 16-bit parameter slots. A host programs it through four narrow ports. Two of them latch a voice number and a function code. The other two form a data port, which can carry a full word, only the low byte or only the high byte. The host issues a write or a read strobe against one of these ports. The synthesis engine reads the same storage through its own read port, addressed directly by voice and slot.

Besides the voice slots, the function code space holds three more items. The first is an active-voice count byte. The second is a control byte whose bit 0 acts as a run/reset gate. The remaining codes are unsupported and read back as all ones. Host reads are registered. A small sequencer has two states. ST_IDLE is the rest state. ST_RESP presents the response for exactly one cycle.

The sequencer has these transitions. ST_IDLE goes to ST_RESP on a read strobe that has no write strobe with it. ST_IDLE stays in ST_IDLE otherwise. ST_RESP goes to ST_RESP again when another lone read strobe arrives, and back to ST_IDLE otherwise.

Top module: `vrf_voice_regs`

## Requirements
- R1: The storage word is selected by voice bits [4:0] and function bits [3:0], giving a word index of voice*16+function and a byte offset of voice*32+function*2. Voice select bits above bit 4 are ignored, so voice 0x21 reaches voice 1.
- R2: Function codes 0x00 to 0x0D write the selected voice slot. Codes 0x80 to 0x8D read the slot with the same low four bits.
- R3: A write on the low data port (host_sel=2) with host_word=1 replaces all 16 bits of the slot.
- R4: A write on the low data port with host_word=0 replaces bits 7:0 with host_wdata[7:0] and keeps bits 15:8.
- R5: A write on the high data port (host_sel=3) places host_wdata[7:0] into bits 15:8 and keeps bits 7:0.
- R6: A word read on the low port returns the whole slot. A byte read on the low port returns {8'h00, bits 7:0}. A read on the high port returns {8'h00, bits 15:8}.
- R7: Voice slot writes have no effect while bit 0 of the control byte is 0. The control byte is 0x00 after rst_n.
- R8: Function 0x0E writes the active-voice count from host_wdata[7:0]. Function 0x8E reads it as {8'h00, count} on any lane. The count is 0xCD after rst_n.
- R9: Function 0x4C writes the control byte. If host_wdata[0] is 0, the count is reloaded with 0xCD and control bits 1 and 2 are stored as 0. Voice slot contents are kept.
- R10: A data-port read with any other function code returns 16'hFFFF on every lane.
- R11: host_rvalid is 1 in exactly the cycle after a read strobe that is not accompanied by a write strobe, and host_rdata is valid in that cycle.
- R12: eng_rdata returns the slot at eng_voice/eng_func one clock after they are presented.
- R13: A read of the voice select port (host_sel=0) or the function select port (host_sel=1) returns {8'h00, latched byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Port: 0 voice select, 1 function select, 2 low data, 3 high data |
| host_word | input | 1 | Full-word access on the low data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response valid |
| mode_ctrl | output | 8 | Current control byte |
| eng_voice | input | 5 | Engine read voice index |
| eng_func | input | 4 | Engine read slot index |
| eng_rdata | output | 16 | Engine read data, one cycle after the address |

## Verification
The bench builds the block with its default sizes of 32 voices by 16 slots. This puts the top voice (31) and the last writable slot (0x0D) within reach, as well as the aliasing of a voice number above 31 onto a lower voice. The full 8-bit function code space can be reached as well, which exposes the boundaries between write codes, read codes, the count codes, the control code and unsupported codes.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    typedef enum logic [1:0] {
        PORT_VOICE = 2'd0,
        PORT_FUNC  = 2'd1,
        PORT_DLO   = 2'd2,
        PORT_DHI   = 2'd3
    } port_e;

    typedef enum logic [2:0] {
        SRC_VSEL,
        SRC_FSEL,
        SRC_MEM,
        SRC_CNT,
        SRC_BAD
    } src_e;

    typedef enum logic [1:0] {
        LANE_WORD,
        LANE_LO,
        LANE_HI
    } lane_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } seq_e;

    localparam logic [7:0] FN_SLOT_WR_LAST = 8'h0D;
    localparam logic [7:0] FN_COUNT_WR     = 8'h0E;
    localparam logic [7:0] FN_SLOT_RD_BASE = 8'h80;
    localparam logic [7:0] FN_SLOT_RD_LAST = 8'h8D;
    localparam logic [7:0] FN_COUNT_RD     = 8'h8E;
    localparam logic [7:0] FN_CTRL         = 8'h4C;
    localparam logic [7:0] COUNT_DEFAULT   = 8'hCD;

    function automatic lane_e lane_of(input port_e p, input logic word);
        if (p == PORT_DHI)
            return LANE_HI;
        else if (word)
            return LANE_WORD;
        else
            return LANE_LO;
    endfunction

endpackage

// File: rtl/vrf_addr_gen.sv
module vrf_addr_gen #(
    parameter int VOICE_BITS = 5,
    parameter int FUNC_BITS  = 4,
    localparam int ADDR_BITS = VOICE_BITS + FUNC_BITS
) (
    input  logic [7:0]           voice_sel,
    input  logic [7:0]           func_sel,
    output logic [ADDR_BITS-1:0] word_addr
);
    // voice picks the bank, function picks the slot within it
    assign word_addr = {voice_sel[VOICE_BITS-1:0], func_sel[FUNC_BITS-1:0]};
endmodule

// File: rtl/vrf_lane.sv
module vrf_lane
    import vrf_pkg::*;
(
    input  lane_e       wr_lane,
    input  logic [15:0] wr_in,
    output logic [1:0]  wr_be,
    output logic [15:0] wr_out,
    input  lane_e       rd_lane,
    input  logic [15:0] rd_in,
    output logic [15:0] rd_out
);
    always_comb begin
        unique case (wr_lane)
            LANE_WORD: begin wr_be = 2'b11; wr_out = wr_in; end
            LANE_LO:   begin wr_be = 2'b01; wr_out = {8'h00, wr_in[7:0]}; end
            LANE_HI:   begin wr_be = 2'b10; wr_out = {wr_in[7:0], 8'h00}; end
            default:   begin wr_be = 2'b00; wr_out = 16'h0000; end
        endcase
    end

    always_comb begin
        unique case (rd_lane)
            LANE_WORD: rd_out = rd_in;
            LANE_LO:   rd_out = {8'h00, rd_in[7:0]};
            LANE_HI:   rd_out = {8'h00, rd_in[15:8]};
            default:   rd_out = 16'hFFFF;
        endcase
    end
endmodule

// File: rtl/vrf_bank.sv
module vrf_bank #(
    parameter int ADDR_BITS = 9,
    parameter int LANES     = 2,
    localparam int DEPTH    = 1 << ADDR_BITS,
    localparam int DW       = LANES * 8
) (
    input  logic                 clk,
    input  logic [ADDR_BITS-1:0] wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [LANES-1:0]     wr_be,
    input  logic                 rd_a_en,
    input  logic [ADDR_BITS-1:0] rd_a_addr,
    output logic [DW-1:0]        rd_a_data,
    input  logic [ADDR_BITS-1:0] rd_b_addr,
    output logic [DW-1:0]        rd_b_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_be[g])
                mem[wr_addr] <= wr_data[g*8 +: 8];
            if (rd_a_en)
                rd_a_data[g*8 +: 8] <= mem[rd_a_addr];
            rd_b_data[g*8 +: 8] <= mem[rd_b_addr];
        end
    end
endmodule

// File: rtl/vrf_voice_regs.sv
module vrf_voice_regs
    import vrf_pkg::*;
#(
    parameter int NUM_VOICES = 32,
    parameter int NUM_FUNCS  = 16,
    localparam int VOICE_BITS = $clog2(NUM_VOICES),
    localparam int FUNC_BITS  = $clog2(NUM_FUNCS),
    localparam int ADDR_BITS  = VOICE_BITS + FUNC_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [1:0]            host_sel,
    input  logic                  host_word,
    input  logic [15:0]           host_wdata,
    output logic [15:0]           host_rdata,
    output logic                  host_rvalid,
    output logic [7:0]            mode_ctrl,
    input  logic [VOICE_BITS-1:0] eng_voice,
    input  logic [FUNC_BITS-1:0]  eng_func,
    output logic [15:0]           eng_rdata
);
    logic [7:0] voice_sel_q, func_sel_q, count_q, ctrl_q, cap_q;
    seq_e       state_q, state_d;
    src_e       src_q, src_d;
    lane_e      lane_q, lane_now;
    port_e      port_now;

    logic                 is_data, fn_slot_wr, fn_slot_rd, rd_take, wr_slot;
    logic [ADDR_BITS-1:0] slot_addr;
    logic [1:0]           lane_be, bank_be;
    logic [15:0]          lane_wdata, bank_rdata, lane_rdata;

    assign port_now   = port_e'(host_sel);
    assign lane_now   = lane_of(port_now, host_word);
    assign is_data    = (port_now == PORT_DLO) || (port_now == PORT_DHI);
    assign fn_slot_wr = (func_sel_q <= FN_SLOT_WR_LAST);
    assign fn_slot_rd = (func_sel_q >= FN_SLOT_RD_BASE) && (func_sel_q <= FN_SLOT_RD_LAST);
    assign rd_take    = host_rd && !host_wr;
    assign wr_slot    = host_wr && is_data && fn_slot_wr && ctrl_q[0];
    assign bank_be    = wr_slot ? lane_be : 2'b00;
    assign mode_ctrl  = ctrl_q;

    vrf_addr_gen #(.VOICE_BITS(VOICE_BITS), .FUNC_BITS(FUNC_BITS)) u_addr (
        .voice_sel (voice_sel_q),
        .func_sel  (func_sel_q),
        .word_addr (slot_addr)
    );

    vrf_lane u_lane (
        .wr_lane (lane_now),
        .wr_in   (host_wdata),
        .wr_be   (lane_be),
        .wr_out  (lane_wdata),
        .rd_lane (lane_q),
        .rd_in   (bank_rdata),
        .rd_out  (lane_rdata)
    );

    vrf_bank #(.ADDR_BITS(ADDR_BITS), .LANES(2)) u_bank (
        .clk       (clk),
        .wr_addr   (slot_addr),
        .wr_data   (lane_wdata),
        .wr_be     (bank_be),
        .rd_a_en   (rd_take),
        .rd_a_addr (slot_addr),
        .rd_a_data (bank_rdata),
        .rd_b_addr ({eng_voice, eng_func}),
        .rd_b_data (eng_rdata)
    );

    // select, count and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            voice_sel_q <= 8'h00;
            func_sel_q  <= 8'h00;
            count_q     <= COUNT_DEFAULT;
            ctrl_q      <= 8'h00;
        end else if (host_wr) begin
            unique case (port_now)
                PORT_VOICE: voice_sel_q <= host_wdata[7:0];
                PORT_FUNC:  func_sel_q  <= host_wdata[7:0];
                default: begin
                    if (func_sel_q == FN_COUNT_WR)
                        count_q <= host_wdata[7:0];
                    if (func_sel_q == FN_CTRL) begin
                        if (host_wdata[0]) begin
                            ctrl_q <= host_wdata[7:0];
                        end else begin
                            ctrl_q  <= host_wdata[7:0] & 8'hF9;
                            count_q <= COUNT_DEFAULT;
                        end
                    end
                end
            endcase
        end
    end

    // read source decode
    always_comb begin
        unique case (port_now)
            PORT_VOICE: src_d = SRC_VSEL;
            PORT_FUNC:  src_d = SRC_FSEL;
            default: begin
                if (fn_slot_rd)                      src_d = SRC_MEM;
                else if (func_sel_q == FN_COUNT_RD)  src_d = SRC_CNT;
                else                                 src_d = SRC_BAD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_BAD;
            lane_q <= LANE_WORD;
            cap_q  <= 8'h00;
        end else if (rd_take) begin
            src_q  <= src_d;
            lane_q <= lane_now;
            unique case (src_d)
                SRC_VSEL: cap_q <= voice_sel_q;
                SRC_FSEL: cap_q <= func_sel_q;
                default:  cap_q <= count_q;
            endcase
        end
    end

    // sequencer: state register
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_take ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_take ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // sequencer: outputs
    always_comb begin
        host_rvalid = 1'b0;
        host_rdata  = 16'h0000;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                host_rvalid = 1'b1;
                unique case (src_q)
                    SRC_MEM:  host_rdata = lane_rdata;
                    SRC_BAD:  host_rdata = 16'hFFFF;
                    default:  host_rdata = {8'h00, cap_q};
                endcase
            end
            default: ;
        endcase
    end

    // R7: slot storage is only written while the run bit is set
    a_r7_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_be != 2'b00) |-> (ctrl_q[0] && host_wr));

    // R9: a control write with bit 0 clear reloads the count and clears bits 2:1
    a_r9_count_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && is_data && func_sel_q == FN_CTRL && !host_wdata[0])
        |=> (count_q == COUNT_DEFAULT && ctrl_q[2:1] == 2'b00));

    // R11: a lone read strobe yields a response in the next cycle
    a_r11_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> host_rvalid);

    // R11: no response without a read in the cycle before
    a_r11_resp_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && !$past(!rst_n)) |-> $past(rd_take));

    // R10: unsupported function codes read as all ones
    a_r10_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && is_data && !fn_slot_rd && func_sel_q != FN_COUNT_RD)
        |=> (host_rdata == 16'hFFFF));
endmodule

// File: tb/vrf_voice_regs_test.sv
module vrf_voice_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0, host_word = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [15:0] host_wdata = 16'h0000;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic [7:0]  mode_ctrl;
    logic [4:0]  eng_voice = 5'd0;
    logic [3:0]  eng_func = 4'd0;
    logic [15:0] eng_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [1:0] P_VOICE = 2'd0, P_FUNC = 2'd1, P_LO = 2'd2, P_HI = 2'd3;

    vrf_voice_regs uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_word(host_word), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mode_ctrl(mode_ctrl),
        .eng_voice(eng_voice), .eng_func(eng_func), .eng_rdata(eng_rdata)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic word, input logic [15:0] d);
        @(negedge clk);
        host_sel = sel; host_word = word; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic word, output logic [15:0] d);
        @(negedge clk);
        host_sel = sel; host_word = word; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check("R11 rvalid", {15'd0, host_rvalid}, 16'd1);
        d = host_rdata;
    endtask

    task automatic pick(input logic [7:0] v, input logic [7:0] f);
        wr(P_VOICE, 1'b0, {8'h00, v});
        wr(P_FUNC, 1'b0, {8'h00, f});
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R11 idle after reset", {15'd0, host_rvalid}, 16'd0);
        check("R7 ctrl reset", {8'h00, mode_ctrl}, 16'h0000);
        pick(8'h00, 8'h8E);
        rd(P_LO, 1'b1, d);
        check("R8 count reset", d, 16'h00CD);
        @(negedge clk);
        check("R11 single-cycle rvalid", {15'd0, host_rvalid}, 16'd0);
    endtask

    task automatic t_gate();
        logic [15:0] d;
        pick(8'h00, 8'h4C);
        wr(P_LO, 1'b0, 16'h0001);
        check("R9 ctrl run", {8'h00, mode_ctrl}, 16'h0001);
        pick(8'h03, 8'h05);
        wr(P_LO, 1'b1, 16'hAAAA);
        pick(8'h00, 8'h4C);
        wr(P_LO, 1'b0, 16'h0000);
        pick(8'h03, 8'h05);
        wr(P_LO, 1'b1, 16'h5555);
        wr(P_HI, 1'b0, 16'h0077);
        pick(8'h00, 8'h4C);
        wr(P_LO, 1'b0, 16'h0001);
        pick(8'h03, 8'h85);
        rd(P_LO, 1'b1, d);
        check("R7 gated write ignored", d, 16'hAAAA);
    endtask

    task automatic t_word();
        logic [15:0] d;
        pick(8'h00, 8'h00);
        wr(P_LO, 1'b1, 16'hBEEF);
        pick(8'h00, 8'h80);
        rd(P_LO, 1'b1, d);
        check("R2 R3 word write/read", d, 16'hBEEF);
    endtask

    task automatic t_bytes();
        logic [15:0] d;
        pick(8'h07, 8'h0D);
        wr(P_LO, 1'b1, 16'h1122);
        wr(P_LO, 1'b0, 16'hFF33);
        pick(8'h07, 8'h8D);
        rd(P_LO, 1'b1, d);
        check("R4 low byte write", d, 16'h1133);
        wr(P_FUNC, 1'b0, 16'h000D);
        wr(P_HI, 1'b0, 16'hEE44);
        wr(P_FUNC, 1'b0, 16'h008D);
        rd(P_LO, 1'b1, d);
        check("R5 high byte write", d, 16'h4433);
        rd(P_LO, 1'b0, d);
        check("R6 low byte read", d, 16'h0033);
        rd(P_HI, 1'b0, d);
        check("R6 high byte read", d, 16'h0044);
    endtask

    task automatic t_addr();
        logic [15:0] d;
        pick(8'h1F, 8'h0D);
        wr(P_LO, 1'b1, 16'hC0DE);
        pick(8'h21, 8'h02);
        wr(P_LO, 1'b1, 16'h0102);
        pick(8'h01, 8'h03);
        wr(P_LO, 1'b1, 16'h0203);
        pick(8'h01, 8'h82);
        rd(P_LO, 1'b1, d);
        check("R1 voice alias", d, 16'h0102);
        pick(8'h1F, 8'h8D);
        rd(P_LO, 1'b1, d);
        check("R1 top voice", d, 16'hC0DE);
        @(negedge clk);
        eng_voice = 5'd31; eng_func = 4'd13;
        @(negedge clk);
        check("R12 engine read top", eng_rdata, 16'hC0DE);
        eng_voice = 5'd1; eng_func = 4'd3;
        @(negedge clk);
        check("R12 engine read slot", eng_rdata, 16'h0203);
    endtask

    task automatic t_sel();
        logic [15:0] d;
        pick(8'h21, 8'h8E);
        rd(P_VOICE, 1'b0, d);
        check("R13 voice select read", d, 16'h0021);
        rd(P_FUNC, 1'b0, d);
        check("R13 function select read", d, 16'h008E);
    endtask

    task automatic t_count();
        logic [15:0] d;
        pick(8'h00, 8'h0E);
        wr(P_LO, 1'b1, 16'h9918);
        wr(P_FUNC, 1'b0, 16'h008E);
        rd(P_LO, 1'b1, d);
        check("R8 count write", d, 16'h0018);
        rd(P_HI, 1'b0, d);
        check("R8 count high lane", d, 16'h0018);
    endtask

    task automatic t_ctrl();
        logic [15:0] d;
        pick(8'h00, 8'h4C);
        wr(P_LO, 1'b0, 16'h0007);
        check("R9 ctrl set", {8'h00, mode_ctrl}, 16'h0007);
        wr(P_FUNC, 1'b0, 16'h008E);
        rd(P_LO, 1'b1, d);
        check("R9 count kept on run write", d, 16'h0018);
        wr(P_FUNC, 1'b0, 16'h004C);
        wr(P_LO, 1'b0, 16'h00F6);
        check("R9 ctrl bits cleared", {8'h00, mode_ctrl}, 16'h00F0);
        wr(P_FUNC, 1'b0, 16'h008E);
        rd(P_LO, 1'b1, d);
        check("R9 count reloaded", d, 16'h00CD);
        pick(8'h1F, 8'h8D);
        rd(P_LO, 1'b1, d);
        check("R9 contents retained", d, 16'hC0DE);
    endtask

    task automatic t_bad();
        logic [15:0] d;
        pick(8'h00, 8'h4C);
        rd(P_LO, 1'b1, d);
        check("R10 ctrl code read", d, 16'hFFFF);
        wr(P_FUNC, 1'b0, 16'h0090);
        rd(P_HI, 1'b0, d);
        check("R10 code 0x90 high lane", d, 16'hFFFF);
        wr(P_FUNC, 1'b0, 16'h000D);
        rd(P_LO, 1'b0, d);
        check("R10 write code read", d, 16'hFFFF);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gate();
        t_word();
        t_bytes();
        t_addr();
        t_sel();
        t_count();
        t_ctrl();
        t_bad();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule